// File: doc/BRIEF.md
# Dual-Speed Clock Brake Controller

This block feeds a CPU from one of two free-running clocks. A fast turbo clock drives the CPU during memory cycles and instruction execution. A slow standard clock drives it while an I/O access is in progress. An active-low I/O request puts the block into a braked state. The brake logic always runs on the slow clock, so it can detect the request only at a slow edge. Once braked, the CPU stays on the slow clock for a fixed number of slow ticks, which gives slow peripherals time to see the request and answer it. A glitch-free multiplexer performs every handover. The clock being left is gated off on its own falling edge. The clock being taken up is enabled only after a two-flop synchroniser in its own domain has seen the other clock go off.

Because the slow domain samples the request, a request that ends before any slow edge sees it would never brake the CPU. A watcher in the fast domain also tracks each request. If a request ends and the slow side has not acknowledged it within a grace window, the watcher raises a sticky error flag.

The brake state machine has three states:

- BRK_IDLE: on the fast clock.
- BRK_HOLD: on the slow clock, counting ticks.
- BRK_RELEASE: handing back to the fast clock.

Its transitions are:

- IDLE→HOLD when a request is seen.
- HOLD→HOLD with the count reloaded when a request is seen again.
- HOLD→RELEASE when the count reaches zero.
- RELEASE→HOLD when a new request is seen.
- RELEASE→IDLE when the fast clock is confirmed on.

The watcher has four states:

- WCH_IDLE: no request.
- WCH_OPEN: request active, not yet acknowledged.
- WCH_DONE: acknowledged.
- WCH_GRACE: the request has ended without an acknowledgement, and the grace window is counting.

Its transitions are:

- IDLE→OPEN when a request is seen.
- OPEN→DONE on an acknowledgement.
- OPEN→GRACE when the request ends unacknowledged.
- DONE→IDLE when both the request and the acknowledgement are low.
- GRACE→IDLE on a late acknowledgement.
- GRACE→IDLE when the window expires, which sets the error flag.

Top module: `dual_clk_brake`

## Requirements
- R1: While rst_n is low, cpu_clk follows slow_clk, and brake_active and io_missed are both 0.
- R2: After reset is released with io_req_n high, cpu_clk switches to fast_clk and brake_active stays 0.
- R3: io_req_n = 0 at a slow_clk rising edge starts a brake. Two slow edges later brake_active becomes 1, and within a few slow ticks cpu_clk follows slow_clk.
- R4: The block holds the slow selection for HOLD_TICKS slow ticks after the last slow edge at which the synchronised request was high. It then returns to fast_clk. With the default of 31 ticks and a request seen at a single slow edge, brake_active stays high for 33 to 40 slow edges.
- R5: A request seen during a brake reloads the tick count, which lengthens the brake by the time elapsed since the previous request.
- R6: No high or low phase of cpu_clk is shorter than half a period of fast_clk, and the two clock enables are never on together.
- R7: brake_active stays high until fast_clk is driving cpu_clk again. At the first cpu_clk pulse after brake_active falls, cpu_clk has the fast high phase.
- R8: A request that the fast domain sees end, and that the slow domain does not acknowledge within GRACE_CYCLES fast cycles, sets io_missed to 1. Such a request starts no brake. io_missed stays 1 until reset, even across later requests.
- R9: A request held low for at least two slow periods is never flagged by io_missed.
- R10: While io_req_n is held low, cpu_clk stays on slow_clk. The hold count runs from the last slow edge that sees the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Free-running turbo clock |
| slow_clk | input | 1 | Free-running standard clock; clocks the brake logic |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser in each domain |
| io_req_n | input | 1 | Active-low I/O request from the CPU |
| cpu_clk | output | 1 | Selected CPU clock |
| brake_active | output | 1 | High from brake latch until the fast clock is selected again |
| io_missed | output | 1 | Sticky flag: an I/O request ended without being latched by the slow domain |

## Verification
The bench builds the block with HOLD_TICKS at 31 and GRACE_CYCLES at 16. It runs the fast clock at 8 ns and the slow clock at 40 ns, offset by 1 ns so that no edges of the two clocks coincide. The full 31-tick hold window can therefore be counted in slow edges. Because the clock ratio is 5, a 16 ns request placed just after a slow edge is missed, while a 48 ns request placed the same way is always latched. The two ratio-limited cases, the missed request and the caught request, therefore sit side by side in the bench. With a 16-cycle grace window, the error flag rises well inside the bench's waiting time.

// File: rtl/dcb_pkg.sv
`timescale 1ns/1ps
package dcb_pkg;

    // Slow-domain brake controller states
    typedef enum logic [1:0] {
        BRK_IDLE,
        BRK_HOLD,
        BRK_RELEASE
    } brake_state_t;

    // Fast-domain request watcher states
    typedef enum logic [1:0] {
        WCH_IDLE,
        WCH_OPEN,
        WCH_DONE,
        WCH_GRACE
    } watch_state_t;

endpackage

// File: rtl/dcb_rst_sync.sv
`timescale 1ns/1ps
module dcb_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/dcb_brake_fsm.sv
`timescale 1ns/1ps
module dcb_brake_fsm
    import dcb_pkg::*;
#(
    parameter int HOLD_TICKS = 31,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req_n,
    input  logic             fast_on,
    output logic             want_slow,
    output logic             brake_active,
    output logic             req_seen,
    output brake_state_t     state,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS - 1);

    logic [1:0]       req_sync;
    logic [1:0]       fast_sync;
    logic             fast_on_s;
    brake_state_t     nxt;
    logic [CNT_W-1:0] nxt_cnt;

    // Two-flop synchronisers into the slow domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sync  <= '0;
            fast_sync <= '0;
        end else begin
            req_sync  <= {req_sync[0], ~io_req_n};
            fast_sync <= {fast_sync[0], fast_on};
        end
    end

    assign req_seen  = req_sync[1];
    assign fast_on_s = fast_sync[1];

    always_comb begin
        nxt     = state;
        nxt_cnt = cnt;
        unique case (state)
            BRK_IDLE: begin
                if (req_seen) begin
                    nxt     = BRK_HOLD;
                    nxt_cnt = RELOAD;
                end
            end
            BRK_HOLD: begin
                if (req_seen)        nxt_cnt = RELOAD;
                else if (cnt == '0)  nxt     = BRK_RELEASE;
                else                 nxt_cnt = cnt - 1'b1;
            end
            BRK_RELEASE: begin
                if (req_seen) begin
                    nxt     = BRK_HOLD;
                    nxt_cnt = RELOAD;
                end else if (fast_on_s) begin
                    nxt = BRK_IDLE;
                end
            end
            default: nxt = BRK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BRK_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
        end
    end

    // Outputs
    always_comb begin
        want_slow    = (state == BRK_HOLD);
        brake_active = (state != BRK_IDLE);
    end
endmodule

// File: rtl/dcb_miss_watch.sv
`timescale 1ns/1ps
module dcb_miss_watch
    import dcb_pkg::*;
#(
    parameter int GRACE_CYCLES = 16,
    parameter int GW           = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_req_n,
    input  logic slow_ack,
    output logic missed
);
    localparam logic [GW-1:0] GRACE_LAST = GW'(GRACE_CYCLES - 1);

    logic [1:0]    req_sync;
    logic [1:0]    ack_sync;
    logic          req_f;
    logic          ack_f;
    watch_state_t  st;
    watch_state_t  st_nxt;
    logic [GW-1:0] gcnt;
    logic [GW-1:0] gcnt_nxt;
    logic          expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sync <= '0;
            ack_sync <= '0;
        end else begin
            req_sync <= {req_sync[0], ~io_req_n};
            ack_sync <= {ack_sync[0], slow_ack};
        end
    end

    assign req_f = req_sync[1];
    assign ack_f = ack_sync[1];

    always_comb begin
        st_nxt   = st;
        gcnt_nxt = gcnt;
        expire   = 1'b0;
        unique case (st)
            WCH_IDLE: begin
                if (req_f) st_nxt = ack_f ? WCH_DONE : WCH_OPEN;
            end
            WCH_OPEN: begin
                if (ack_f) begin
                    st_nxt = WCH_DONE;
                end else if (!req_f) begin
                    st_nxt   = WCH_GRACE;
                    gcnt_nxt = GRACE_LAST;
                end
            end
            WCH_DONE: begin
                if (!req_f && !ack_f) st_nxt = WCH_IDLE;
            end
            WCH_GRACE: begin
                if (ack_f) begin
                    st_nxt = WCH_IDLE;
                end else if (gcnt == '0) begin
                    st_nxt = WCH_IDLE;
                    expire = 1'b1;
                end else begin
                    gcnt_nxt = gcnt - 1'b1;
                end
            end
            default: st_nxt = WCH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= WCH_IDLE;
            gcnt <= '0;
        end else begin
            st   <= st_nxt;
            gcnt <= gcnt_nxt;
        end
    end

    // Outputs: sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      missed <= 1'b0;
        else if (expire) missed <= 1'b1;
    end
endmodule

// File: rtl/dcb_clk_mux.sv
`timescale 1ns/1ps
module dcb_clk_branch #(
    parameter bit ON_AT_RESET = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_en,
    output logic en
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{ON_AT_RESET}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], want & ~other_en};
    end

    // Enable moves only while this clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en <= ON_AT_RESET;
        else        en <= sync_q[SYNC_STAGES-1];
    end
endmodule

module dcb_clk_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic fast_clk,
    input  logic slow_clk,
    input  logic frst_n,
    input  logic srst_n,
    input  logic want_slow,
    output logic cpu_clk,
    output logic fast_en,
    output logic slow_en
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] clk_v;
    logic [NSRC-1:0] rst_v;
    logic [NSRC-1:0] want_v;
    logic [NSRC-1:0] en_v;

    // Index 0 = fast source, index 1 = slow source
    assign clk_v  = {slow_clk, fast_clk};
    assign rst_v  = {srst_n, frst_n};
    assign want_v = {want_slow, ~want_slow};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        dcb_clk_branch #(
            .ON_AT_RESET (g == 1),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_branch (
            .clk      (clk_v[g]),
            .rst_n    (rst_v[g]),
            .want     (want_v[g]),
            .other_en (en_v[NSRC-1-g]),
            .en       (en_v[g])
        );
    end

    assign cpu_clk = |(clk_v & en_v);
    assign fast_en = en_v[0];
    assign slow_en = en_v[1];
endmodule

// File: rtl/dual_clk_brake.sv
`timescale 1ns/1ps
module dual_clk_brake
    import dcb_pkg::*;
#(
    parameter int HOLD_TICKS   = 31,
    parameter int GRACE_CYCLES = 16,
    parameter int RST_STAGES   = 2
) (
    input  logic fast_clk,
    input  logic slow_clk,
    input  logic rst_n,
    input  logic io_req_n,
    output logic cpu_clk,
    output logic brake_active,
    output logic io_missed
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam int GW    = $clog2(GRACE_CYCLES + 1);

    logic             srst_n;
    logic             frst_n;
    logic             want_slow;
    logic             req_seen_s;
    logic             fast_en;
    logic             slow_en;
    brake_state_t     brk_state;
    logic [CNT_W-1:0] hold_cnt;

    dcb_rst_sync #(.STAGES(RST_STAGES)) u_rs_slow (
        .clk     (slow_clk),
        .arst_n  (rst_n),
        .rst_n_o (srst_n)
    );

    dcb_rst_sync #(.STAGES(RST_STAGES)) u_rs_fast (
        .clk     (fast_clk),
        .arst_n  (rst_n),
        .rst_n_o (frst_n)
    );

    dcb_brake_fsm #(
        .HOLD_TICKS (HOLD_TICKS),
        .CNT_W      (CNT_W)
    ) u_brake (
        .clk          (slow_clk),
        .rst_n        (srst_n),
        .io_req_n     (io_req_n),
        .fast_on      (fast_en),
        .want_slow    (want_slow),
        .brake_active (brake_active),
        .req_seen     (req_seen_s),
        .state        (brk_state),
        .cnt          (hold_cnt)
    );

    dcb_miss_watch #(
        .GRACE_CYCLES (GRACE_CYCLES),
        .GW           (GW)
    ) u_watch (
        .clk      (fast_clk),
        .rst_n    (frst_n),
        .io_req_n (io_req_n),
        .slow_ack (req_seen_s),
        .missed   (io_missed)
    );

    dcb_clk_mux #(.SYNC_STAGES(2)) u_mux (
        .fast_clk  (fast_clk),
        .slow_clk  (slow_clk),
        .frst_n    (frst_n),
        .srst_n    (srst_n),
        .want_slow (want_slow),
        .cpu_clk   (cpu_clk),
        .fast_en   (fast_en),
        .slow_en   (slow_en)
    );
endmodule

// File: rtl/dcb_checker.sv
`timescale 1ns/1ps
module dcb_checker
    import dcb_pkg::*;
#(
    parameter int HOLD_TICKS = 31,
    parameter int CNT_W      = 6
) (
    input logic             fast_clk,
    input logic             slow_clk,
    input logic             srst_n,
    input logic             frst_n,
    input logic             slow_req,
    input brake_state_t     brk_state,
    input logic [CNT_W-1:0] hold_cnt,
    input logic             fast_en,
    input logic             slow_en,
    input logic             brake_active,
    input logic             io_missed
);
    logic in_hold;
    assign in_hold = (brk_state == BRK_HOLD);

    // R3: a latched request raises the brake status on the next slow edge
    p_brake_starts_r3: assert property (@(posedge slow_clk) disable iff (!srst_n)
        slow_req |=> brake_active);

    // R5: every latched request reloads the hold count
    p_count_reload_r5: assert property (@(posedge slow_clk) disable iff (!srst_n)
        slow_req |=> (in_hold && hold_cnt == CNT_W'(HOLD_TICKS - 1)));

    // R4: a hold lasting six slow edges has the slow clock alone enabled
    p_slow_in_hold_r4: assert property (@(posedge slow_clk) disable iff (!srst_n)
        (in_hold && $past(in_hold, 1) && $past(in_hold, 2) && $past(in_hold, 3)
         && $past(in_hold, 4) && $past(in_hold, 5)) |-> (slow_en && !fast_en));

    // R6: the two enables never overlap
    p_excl_fast_r6: assert property (@(posedge fast_clk) disable iff (!frst_n)
        !(fast_en && slow_en));
    p_excl_slow_r6: assert property (@(posedge slow_clk) disable iff (!srst_n)
        !(fast_en && slow_en));

    // R8: the miss flag holds once set
    p_missed_sticky_r8: assert property (@(posedge fast_clk) disable iff (!frst_n)
        io_missed |=> io_missed);
endmodule

bind dual_clk_brake dcb_checker #(
    .HOLD_TICKS (HOLD_TICKS),
    .CNT_W      (CNT_W)
) u_chk (
    .fast_clk     (fast_clk),
    .slow_clk     (slow_clk),
    .srst_n       (srst_n),
    .frst_n       (frst_n),
    .slow_req     (req_seen_s),
    .brk_state    (brk_state),
    .hold_cnt     (hold_cnt),
    .fast_en      (fast_en),
    .slow_en      (slow_en),
    .brake_active (brake_active),
    .io_missed    (io_missed)
);

// File: tb/sim_dual_clk_brake.sv
`timescale 1ns/1ps
module sim_dual_clk_brake;
    logic fast_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic io_req_n = 1'b1;
    logic cpu_clk;
    logic brake_active;
    logic io_missed;

    int checks   = 0;
    int errors   = 0;
    int brk_run  = 0;
    int glitches = 0;

    dual_clk_brake #(
        .HOLD_TICKS   (31),
        .GRACE_CYCLES (16),
        .RST_STAGES   (2)
    ) u0 (
        .fast_clk     (fast_clk),
        .slow_clk     (slow_clk),
        .rst_n        (rst_n),
        .io_req_n     (io_req_n),
        .cpu_clk      (cpu_clk),
        .brake_active (brake_active),
        .io_missed    (io_missed)
    );

    // 125 MHz fast clock, 25 MHz slow clock offset by 1 ns
    initial forever #4 fast_clk = ~fast_clk;
    initial begin
        #1;
        forever #20 slow_clk = ~slow_clk;
    end

    // Count slow edges with the brake status high
    always @(posedge slow_clk) begin
        #1;
        if (brake_active === 1'b1) brk_run++;
    end

    // Phase-width monitor on the CPU clock (R6)
    realtime last_edge = 0.0;
    bit      seen_edge = 1'b0;
    always @(cpu_clk) begin
        if ($realtime > 10.0) begin
            if (seen_edge && ($realtime - last_edge) < 3.5) glitches++;
            seen_edge = 1'b1;
            last_edge = $realtime;
        end
    end

    task automatic chk_rng(string tag, int got, int lo, int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    task automatic chk_eq(string tag, int got, int exp);
        chk_rng(tag, got, exp, exp);
    endtask

    task automatic high_width(output int w);
        realtime t0;
        @(posedge cpu_clk);
        t0 = $realtime;
        @(negedge cpu_clk);
        w = int'($realtime - t0);
    endtask

    task automatic req_pulse(int ns);
        @(posedge slow_clk);
        #2;
        io_req_n = 1'b0;
        #(ns);
        io_req_n = 1'b1;
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 20; i++) begin
            @(posedge slow_clk);
            #2;
            if (brake_active) break;
        end
    endtask

    task automatic wait_fall();
        for (int i = 0; i < 300; i++) begin
            @(posedge slow_clk);
            #2;
            if (!brake_active) break;
        end
    endtask

    task automatic do_reset();
        io_req_n = 1'b1;
        rst_n    = 1'b0;
        repeat (4) @(posedge slow_clk);
        #3 rst_n = 1'b1;
        repeat (12) @(posedge slow_clk);
        #2 brk_run = 0;
    endtask

    task automatic t_reset_state();
        int w;
        rst_n = 1'b0;
        repeat (3) @(posedge slow_clk);
        #2;
        chk_eq("R1 brake_active in reset", brake_active, 0);
        chk_eq("R1 io_missed in reset", io_missed, 0);
        high_width(w);
        chk_eq("R1 cpu_clk high ns in reset (slow)", w, 20);
    endtask

    task automatic t_fast_after_reset();
        int w;
        do_reset();
        high_width(w);
        chk_eq("R2 cpu_clk high ns after reset (fast)", w, 4);
        chk_eq("R2 brake_active idle", brake_active, 0);
    endtask

    task automatic t_single_brake();
        int w;
        brk_run = 0;
        req_pulse(48);
        wait_rise();
        chk_eq("R3 brake_active after request", brake_active, 1);
        repeat (6) @(posedge slow_clk);
        high_width(w);
        chk_eq("R3 cpu_clk high ns during brake (slow)", w, 20);
        wait_fall();
        chk_rng("R4 brake length in slow edges", brk_run, 33, 40);
        high_width(w);
        chk_eq("R7 cpu_clk high ns after brake drop (fast)", w, 4);
        chk_eq("R9 no miss for latched request", io_missed, 0);
    endtask

    task automatic t_restart();
        brk_run = 0;
        req_pulse(48);
        wait_rise();
        repeat (14) @(posedge slow_clk);
        req_pulse(48);
        wait_fall();
        chk_rng("R5 restarted brake length", brk_run, 50, 58);
    endtask

    task automatic t_long_request();
        int w;
        brk_run = 0;
        fork
            req_pulse(800);
            begin
                repeat (10) @(posedge slow_clk);
                high_width(w);
                chk_eq("R10 cpu_clk high ns while request held", w, 20);
            end
        join
        wait_fall();
        chk_rng("R10 brake length after held request", brk_run, 52, 60);
    endtask

    task automatic t_two_period_request();
        brk_run = 0;
        req_pulse(80);
        wait_rise();
        wait_fall();
        repeat (40) @(posedge fast_clk);
        #1;
        chk_eq("R9 io_missed after two-period request", io_missed, 0);
    endtask

    task automatic t_missed();
        do_reset();
        brk_run = 0;
        req_pulse(16);
        repeat (60) @(posedge fast_clk);
        #1;
        chk_eq("R8 io_missed after short request", io_missed, 1);
        chk_eq("R8 no brake for missed request", brk_run, 0);
        req_pulse(48);
        wait_rise();
        wait_fall();
        chk_eq("R8 io_missed sticky across later request", io_missed, 1);
        rst_n = 1'b0;
        #3;
        chk_eq("R1 io_missed cleared by reset", io_missed, 0);
        do_reset();
    endtask

    initial begin
        t_reset_state();
        t_fast_after_reset();
        t_single_brake();
        t_restart();
        t_long_request();
        t_two_period_request();
        t_missed();
        chk_eq("R6 short cpu_clk phases", glitches, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule